// File: doc/BRIEF.md
# Wormhole Mesh Router

This block is one node of a two-dimensional mesh on chip. It has five ports: east (X+), west (X-), north (Y+), south (Y-) and the attached core. Each port carries 64-bit flits one way in and one way out. Packets move by wormhole switching. An incoming flit lands in a small registered buffer on its input. The head of a packet then passes through three stages, each one cycle long: a route stage, a combined channel and switch allocation stage, and a traversal stage through a 5x5 crossbar into an output register.

Once a head wins an output, that output stays with its input until the tail has gone through. The body and tail flits skip routing and allocation and stream out one cycle apart. Routing is dimension-ordered: the X coordinate is corrected first, then Y, and a packet that has arrived goes to the core port. Each output keeps a credit count of the free slots in the next router's buffer. It sends nothing while that count is zero. Each input hands a credit back upstream for every flit that leaves its buffer. The node's own coordinates are parameters.

Top module: `mesh_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every bit of `out_valid` and `credit_out` is low. Every output starts with 4 credits and its arbiter pointer at port 0.
- R2: A head is routed by comparing its destination (X, Y) with the parameters `MY_X` and `MY_Y`. If X is larger it leaves on port 0 (X+). If X is smaller it leaves on port 1 (X-). If X is equal, a larger Y goes to port 2 (Y+) and a smaller Y goes to port 3 (Y-). If both are equal it goes to port 4 (core). The other outputs stay silent.
- R3: A head captured at clock edge k appears on its output after edge k+3, provided the output is free and has credit.
- R4: The body and tail flits of a packet leave the same output one cycle after each other, with the same 64 bits they entered with.
- R5: An output stays assigned to one input from the head until the tail. The flits of two packets that compete for one output never interleave. The second packet's head appears two cycles after the first packet's tail.
- R6: Heads that compete for a free output in the same cycle are served round-robin. The search starts at the pointer, in increasing port order with wraparound. After a grant the pointer moves to the port just past the winner.
- R7: An output with zero credits sends nothing. Each pulse on `credit_in` lets exactly one more flit out. The count never exceeds the buffer depth of 4.
- R8: `credit_out` of an input pulses once, for one cycle, for each flit that leaves that input's buffer.
- R9: The flit format is as follows. Bits [63:62] hold the type: 01 head, 10 body, 11 tail. In a head, bits [61:59] hold the destination X and bits [58:56] hold the destination Y. All other bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 5 | A flit is present on the matching input port |
| in_flit | input | 5x64 | Incoming flit for each input port |
| credit_out | output | 5 | One-cycle credit returned upstream per flit taken from an input buffer |
| out_valid | output | 5 | A flit is present on the matching output port |
| out_flit | output | 5x64 | Outgoing flit for each output port |
| credit_in | input | 5 | One-cycle credit returned by the downstream buffer of each output |

## Verification
The assertions assume that upstream senders respect the credits, so a flit never arrives at a full buffer. They also assume that every packet begins with a head and ends with a tail, and that only a downstream buffer that has freed a slot pulses `credit_in`. The stimulus keeps to these rules: each input receives at most one four-flit packet until its credits have come back, packets are always well formed, and credits are returned either one cycle after each output flit or by hand pulses that never add up to more than the flits sent.

// File: rtl/mesh_router_pkg.sv
`timescale 1ns/1ps
package mesh_router_pkg;
  localparam int NPORT = 5;
  localparam int PIDX_W = 3;

  localparam logic [1:0] FT_HEAD = 2'b01;
  localparam logic [1:0] FT_BODY = 2'b10;
  localparam logic [1:0] FT_TAIL = 2'b11;

  typedef enum int {
    P_XP  = 0,
    P_XM  = 1,
    P_YP  = 2,
    P_YM  = 3,
    P_LOC = 4
  } port_e;

  typedef enum logic [1:0] {
    IN_RC  = 2'd0,
    IN_VSA = 2'd1,
    IN_ST  = 2'd2
  } in_state_e;
endpackage

// File: rtl/router_fifo.sv
`timescale 1ns/1ps
module router_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         not_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (wr_en) wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (rd_en) rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    if (wr_en && !rd_en)      count_d = count_q + 1'b1;
    else if (!wr_en && rd_en) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end

  assign rd_data   = mem[rd_ptr_q];
  assign not_empty = (count_q != '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(DEPTH) && !rd_en) |-> !wr_en);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> not_empty);
endmodule

// File: rtl/router_input.sv
`timescale 1ns/1ps
module router_input
  import mesh_router_pkg::*;
#(
  parameter int FLIT_W  = 64,
  parameter int COORD_W = 3,
  parameter int DEPTH   = 4,
  parameter int MY_X    = 3,
  parameter int MY_Y    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic              grant,
  input  logic              send,
  output logic [NPORT-1:0]  req,
  output logic [FLIT_W-1:0] head_flit,
  output logic              head_ok,
  output logic              credit_out
);
  localparam int TYPE_HI = FLIT_W - 1;
  localparam int DX_HI   = FLIT_W - 3;
  localparam int DY_HI   = FLIT_W - 3 - COORD_W;

  in_state_e         state_q, state_d;
  logic [NPORT-1:0]  route_q, route_d;
  logic              route_en;
  logic              credit_q;
  logic [1:0]        ftype;
  logic [COORD_W-1:0] dst_x, dst_y;

  router_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (in_valid),
    .wr_data   (in_flit),
    .rd_en     (send),
    .rd_data   (head_flit),
    .not_empty (head_ok)
  );

  assign ftype = head_flit[TYPE_HI -: 2];
  assign dst_x = head_flit[DX_HI -: COORD_W];
  assign dst_y = head_flit[DY_HI -: COORD_W];

  // route computation (dimension order: X, then Y, then core)
  always_comb begin
    route_d = '0;
    if (dst_x > COORD_W'(MY_X))      route_d[P_XP]  = 1'b1;
    else if (dst_x < COORD_W'(MY_X)) route_d[P_XM]  = 1'b1;
    else if (dst_y > COORD_W'(MY_Y)) route_d[P_YP]  = 1'b1;
    else if (dst_y < COORD_W'(MY_Y)) route_d[P_YM]  = 1'b1;
    else                             route_d[P_LOC] = 1'b1;
  end

  always_comb begin
    state_d  = state_q;
    route_en = 1'b0;
    unique case (state_q)
      IN_RC: if (head_ok && ftype == FT_HEAD) begin
        state_d  = IN_VSA;
        route_en = 1'b1;
      end
      IN_VSA: if (grant) state_d = IN_ST;
      IN_ST:  if (send && ftype == FT_TAIL) state_d = IN_RC;
      default: state_d = IN_RC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= IN_RC;
      route_q  <= '0;
      credit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      credit_q <= send;
      if (route_en) route_q <= route_d;
    end
  end

  assign req        = (state_q == IN_VSA) ? route_q : '0;
  assign credit_out = credit_q;

  // R9
  vsa_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IN_VSA) |-> (head_ok && ftype == FT_HEAD));

  // R5
  send_streaming_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send |-> (state_q == IN_ST));
endmodule

// File: rtl/rr_arbiter.sv
`timescale 1ns/1ps
module rr_arbiter #(
  parameter int N = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 adv,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          found;
  int            p;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    p       = 0;
    for (int k = 0; k < N; k++) begin
      p = int'(ptr_q) + k;
      if (p >= N) p = p - N;
      if (!found && req[p]) begin
        found   = 1'b1;
        gnt[p]  = 1'b1;
        gnt_idx = IW'(p);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv && found) ptr_d = (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R6
  gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R6
  gnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> $onehot(gnt));
endmodule

// File: rtl/router_output.sv
`timescale 1ns/1ps
module router_output
  import mesh_router_pkg::*;
#(
  parameter int FLIT_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             req_col,
  input  logic [NPORT-1:0][FLIT_W-1:0] heads,
  input  logic [NPORT-1:0]             head_ok,
  input  logic                         credit_in,
  output logic [NPORT-1:0]             grant_sel,
  output logic [NPORT-1:0]             send_sel,
  output logic                         out_valid,
  output logic [FLIT_W-1:0]            out_flit
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(NPORT);

  logic              locked_q, locked_d;
  logic [IW-1:0]     owner_q, owner_d;
  logic [CW-1:0]     cred_q, cred_d;
  logic              oval_q;
  logic [FLIT_W-1:0] oflit_q;
  logic [NPORT-1:0]  arb_req, arb_gnt;
  logic [IW-1:0]     arb_idx;
  logic              arb_adv, sending;
  logic [FLIT_W-1:0] sel_flit;

  assign arb_req = locked_q ? '0 : req_col;
  assign arb_adv = !locked_q && (req_col != '0);

  rr_arbiter #(.N(NPORT)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (arb_req),
    .adv     (arb_adv),
    .gnt     (arb_gnt),
    .gnt_idx (arb_idx)
  );

  assign sel_flit = heads[owner_q];
  assign sending  = locked_q && head_ok[owner_q] && (cred_q != '0);

  always_comb begin
    locked_d = locked_q;
    owner_d  = owner_q;
    if (arb_adv) begin
      locked_d = 1'b1;
      owner_d  = arb_idx;
    end else if (sending && sel_flit[FLIT_W-1 -: 2] == FT_TAIL) begin
      locked_d = 1'b0;
    end
    cred_d = cred_q;
    if (sending && !credit_in)      cred_d = cred_q - 1'b1;
    else if (!sending && credit_in) cred_d = cred_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      cred_q   <= CW'(DEPTH);
      oval_q   <= 1'b0;
      oflit_q  <= '0;
    end else begin
      locked_q <= locked_d;
      owner_q  <= owner_d;
      cred_q   <= cred_d;
      oval_q   <= sending;
      if (sending) oflit_q <= sel_flit;
    end
  end

  assign grant_sel = arb_gnt;
  assign send_sel  = sending ? (NPORT'(1) << owner_q) : '0;
  assign out_valid = oval_q;
  assign out_flit  = oflit_q;

  // R7
  cred_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cred_q <= CW'(DEPTH));

  // R7
  cred_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_q == '0) |=> !out_valid);

  // R3
  head_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked_q) && cred_q != '0) |=> (out_valid && out_flit[FLIT_W-1 -: 2] == FT_HEAD));

  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && $past(locked_q)) |-> $stable(owner_q));
endmodule

// File: rtl/mesh_router.sv
`timescale 1ns/1ps
module mesh_router
  import mesh_router_pkg::*;
#(
  parameter int FLIT_W     = 64,
  parameter int COORD_W    = 3,
  parameter int FIFO_DEPTH = 4,
  parameter int MY_X       = 3,
  parameter int MY_Y       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             in_valid,
  input  logic [NPORT-1:0][FLIT_W-1:0] in_flit,
  output logic [NPORT-1:0]             credit_out,
  output logic [NPORT-1:0]             out_valid,
  output logic [NPORT-1:0][FLIT_W-1:0] out_flit,
  input  logic [NPORT-1:0]             credit_in
);
  // matrices indexed [input][output] and [output][input]
  logic [NPORT-1:0][NPORT-1:0] req_io, req_oi;
  logic [NPORT-1:0][NPORT-1:0] gnt_oi, snd_oi, snd_io;
  logic [NPORT-1:0]            grant_in, send_in, head_ok;
  logic [NPORT-1:0][FLIT_W-1:0] heads;

  always_comb begin
    grant_in = '0;
    send_in  = '0;
    for (int i = 0; i < NPORT; i++) begin
      for (int o = 0; o < NPORT; o++) begin
        req_oi[o][i] = req_io[i][o];
        snd_io[i][o] = snd_oi[o][i];
        grant_in[i]  = grant_in[i] | gnt_oi[o][i];
        send_in[i]   = send_in[i]  | snd_oi[o][i];
      end
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    router_input #(
      .FLIT_W (FLIT_W), .COORD_W (COORD_W), .DEPTH (FIFO_DEPTH),
      .MY_X   (MY_X),   .MY_Y    (MY_Y)
    ) u_in (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid[i]),
      .in_flit    (in_flit[i]),
      .grant      (grant_in[i]),
      .send       (send_in[i]),
      .req        (req_io[i]),
      .head_flit  (heads[i]),
      .head_ok    (head_ok[i]),
      .credit_out (credit_out[i])
    );

    // R5
    one_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(snd_io[i]));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    router_output #(.FLIT_W (FLIT_W), .DEPTH (FIFO_DEPTH)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_col   (req_oi[o]),
      .heads     (heads),
      .head_ok   (head_ok),
      .credit_in (credit_in[o]),
      .grant_sel (gnt_oi[o]),
      .send_sel  (snd_oi[o]),
      .out_valid (out_valid[o]),
      .out_flit  (out_flit[o])
    );
  end
endmodule

// File: tb/sim_mesh_router.sv
`timescale 1ns/1ps
module sim_mesh_router;
  localparam int NP = 5;
  localparam int FW = 64;

  logic                   clk;
  logic                   rst_n;
  logic [NP-1:0]          in_valid;
  logic [NP-1:0][FW-1:0]  in_flit;
  logic [NP-1:0]          credit_out;
  logic [NP-1:0]          out_valid;
  logic [NP-1:0][FW-1:0]  out_flit;
  logic [NP-1:0]          credit_in;
  logic [NP-1:0]          ret_q, man_cred, auto_cred;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [FW-1:0] rx_f [NP][32];
  int            rx_c [NP][32];
  int            rx_n [NP];
  int            cr_n [NP];

  // vector: {src, dst_x, dst_y, expected output port}
  localparam logic [11:0] VEC [8] = '{
    {3'd4, 3'd5, 3'd3, 3'd0},
    {3'd4, 3'd0, 3'd7, 3'd1},
    {3'd1, 3'd3, 3'd6, 3'd2},
    {3'd0, 3'd3, 3'd1, 3'd3},
    {3'd2, 3'd3, 3'd3, 3'd4},
    {3'd3, 3'd7, 3'd0, 3'd0},
    {3'd4, 3'd2, 3'd2, 3'd1},
    {3'd0, 3'd3, 3'd4, 3'd2}
  };

  mesh_router #(.MY_X(3), .MY_Y(3)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_flit    (in_flit),
    .credit_out (credit_out),
    .out_valid  (out_valid),
    .out_flit   (out_flit),
    .credit_in  (credit_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  assign credit_in = ret_q | man_cred;

  // downstream model and output monitor
  always @(negedge clk) begin
    for (int o = 0; o < NP; o++) begin
      ret_q[o] <= out_valid[o] & auto_cred[o];
      if (rst_n && out_valid[o] && rx_n[o] < 32) begin
        rx_f[o][rx_n[o]] = out_flit[o];
        rx_c[o][rx_n[o]] = cyc;
        rx_n[o] = rx_n[o] + 1;
      end
      if (rst_n && credit_out[o]) cr_n[o] = cr_n[o] + 1;
    end
  end

  function automatic logic [FW-1:0] pkt_flit(input int k, input logic [2:0] dx,
                                             input logic [2:0] dy, input logic [15:0] tag);
    logic [1:0] t;
    t = (k == 0) ? 2'b01 : (k == 3) ? 2'b11 : 2'b10;
    if (k == 0) return {t, dx, dy, 40'h5A5A_0F0F_33, tag};
    return {t, 6'h2A, 40'hC3C3_1234_9A, tag + 16'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                     input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    for (int o = 0; o < NP; o++) begin
      rx_n[o] = 0;
      cr_n[o] = 0;
    end
  endtask

  task automatic drive_pkt(input int src, input logic [2:0] dx, input logic [2:0] dy,
                           input logic [15:0] tag, output int c0);
    @(negedge clk);
    c0 = cyc;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      in_valid[src] = 1'b1;
      in_flit[src]  = pkt_flit(k, dx, dy, tag);
    end
    @(negedge clk);
    in_valid[src] = 1'b0;
    in_flit[src]  = '0;
  endtask

  task automatic pulse_cred(input int o);
    @(negedge clk);
    man_cred[o] = 1'b1;
    @(negedge clk);
    man_cred[o] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1 out_valid in reset", 64'(out_valid), 0);
    chk(credit_out == '0, "R1 credit_out in reset", 64'(credit_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0 && credit_out == '0, "R1 after release",
        64'({out_valid, credit_out}), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ca, cb, cc, cd;
    in_valid  = '0;
    in_flit   = '0;
    man_cred  = '0;
    auto_cred = '1;
    ret_q     = '0;
    clear_logs();
    do_reset();

    // table walk: routing, latency, streaming, credit return
    for (int v = 0; v < 8; v++) begin
      int src, ep, c0, tot;
      logic [2:0] dx, dy;
      logic [15:0] tag;
      src = int'(VEC[v][11:9]);
      dx  = VEC[v][8:6];
      dy  = VEC[v][5:3];
      ep  = int'(VEC[v][2:0]);
      tag = 16'(v * 16 + 16'h100);
      @(posedge clk);
      clear_logs();
      drive_pkt(src, dx, dy, tag, c0);
      repeat (10) @(negedge clk);
      tot = 0;
      for (int o = 0; o < NP; o++) tot += rx_n[o];
      chk(rx_n[ep] == 4, "R2 flits on routed port", 64'(rx_n[ep]), 4);
      chk(tot == 4, "R2 other ports silent", 64'(tot), 4);
      chk(rx_c[ep][0] == c0 + 4, "R3 head latency", 64'(rx_c[ep][0] - c0), 4);
      for (int k = 1; k < 4; k++)
        chk(rx_c[ep][k] == c0 + 4 + k, "R4 body spacing", 64'(rx_c[ep][k] - c0), 64'(4 + k));
      for (int k = 0; k < 4; k++)
        chk(rx_f[ep][k] == pkt_flit(k, dx, dy, tag), "R4 R9 flit content",
            rx_f[ep][k], pkt_flit(k, dx, dy, tag));
      chk(cr_n[src] == 4, "R8 credits returned", 64'(cr_n[src]), 4);
    end

    // contention for the core port after a fresh reset
    do_reset();
    @(posedge clk);
    clear_logs();
    fork
      drive_pkt(1, 3'd3, 3'd3, 16'hA000, ca);
      drive_pkt(3, 3'd3, 3'd3, 16'hB000, cb);
    join
    repeat (14) @(negedge clk);
    chk(rx_n[4] == 8, "R5 both packets delivered", 64'(rx_n[4]), 8);
    for (int k = 0; k < 4; k++) begin
      chk(rx_f[4][k] == pkt_flit(k, 3'd3, 3'd3, 16'hA000), "R6 pointer 0 serves port 1 first",
          rx_f[4][k], pkt_flit(k, 3'd3, 3'd3, 16'hA000));
      chk(rx_f[4][k+4] == pkt_flit(k, 3'd3, 3'd3, 16'hB000), "R5 no interleave",
          rx_f[4][k+4], pkt_flit(k, 3'd3, 3'd3, 16'hB000));
    end
    chk(rx_c[4][4] == ca + 9, "R5 second head after release", 64'(rx_c[4][4] - ca), 9);

    // pointer now at 4: port 4 must beat port 0
    @(posedge clk);
    clear_logs();
    fork
      drive_pkt(0, 3'd3, 3'd3, 16'hC000, cc);
      drive_pkt(4, 3'd3, 3'd3, 16'hD000, cd);
    join
    repeat (14) @(negedge clk);
    chk(rx_f[4][0] == pkt_flit(0, 3'd3, 3'd3, 16'hD000), "R6 rotation past winner",
        rx_f[4][0], pkt_flit(0, 3'd3, 3'd3, 16'hD000));
    chk(rx_f[4][4] == pkt_flit(0, 3'd3, 3'd3, 16'hC000), "R6 loser served next",
        rx_f[4][4], pkt_flit(0, 3'd3, 3'd3, 16'hC000));

    // credit exhaustion on port 2
    auto_cred[2] = 1'b0;
    @(posedge clk);
    clear_logs();
    drive_pkt(4, 3'd3, 3'd5, 16'hE000, ca);
    repeat (10) @(negedge clk);
    chk(rx_n[2] == 4, "R7 four credits at start", 64'(rx_n[2]), 4);
    drive_pkt(1, 3'd3, 3'd6, 16'hF000, cb);
    repeat (10) @(negedge clk);
    chk(rx_n[2] == 4, "R7 stalled at zero credit", 64'(rx_n[2]), 4);
    pulse_cred(2);
    repeat (5) @(negedge clk);
    chk(rx_n[2] == 5, "R7 one credit one flit", 64'(rx_n[2]), 5);
    chk(rx_f[2][4] == pkt_flit(0, 3'd3, 3'd6, 16'hF000), "R7 stalled head released",
        rx_f[2][4], pkt_flit(0, 3'd3, 3'd6, 16'hF000));
    for (int k = 0; k < 3; k++) pulse_cred(2);
    repeat (5) @(negedge clk);
    chk(rx_n[2] == 8, "R7 remaining flits after credits", 64'(rx_n[2]), 8);
    chk(rx_f[2][7] == pkt_flit(3, 3'd3, 3'd6, 16'hF000), "R7 tail intact",
        rx_f[2][7], pkt_flit(3, 3'd3, 3'd6, 16'hF000));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule